// File: doc/BRIEF.md
# Five-Phase Multi-Cycle Processor Core

This block is a small processor that does not overlap instructions. Every instruction passes through five phases in a fixed sequence, one phase per clock. The phases are fetch, decode with operand read, execute, memory access and write-back. The core holds a 32-entry register file of 8-bit values, a word-addressed instruction store and a data store. Both stores are filled through a load port while the core is held in reset. Three operations are supported: register-register add, move-immediate, and store with base-plus-offset addressing. Every other opcode passes through the five phases and changes nothing.

The integrator fills the instruction store, optionally presets the data store, and then releases reset. The program runs until the core fetches a word of all ones. It then parks in a halt state. The current phase and program counter are visible at the ports. Two combinational debug ports read any register and any data word at any time.

The control is a single enumerated state machine with six states. IDLE is not used. The states and their codes are:

| State | Code |
|-------|------|
| FETCH | 0 |
| DECODE | 1 |
| EXECUTE | 2 |
| MEMORY | 3 |
| WRITEBACK | 4 |
| HALT | 5 |

The transitions are:

- FETCH→DECODE, when the fetched word is not all ones.
- FETCH→HALT, when the fetched word is all ones.
- DECODE→EXECUTE, always.
- EXECUTE→MEMORY, always.
- MEMORY→WRITEBACK, always.
- WRITEBACK→FETCH, always.
- HALT→HALT, until reset.

Top module: `mc5_core`

## Requirements
- R1: After reset, the phase output steps through the sequence 0, 1, 2, 3, 4, 0 with one step per clock, so that each non-halting instruction occupies exactly five cycles. The codes are FETCH=0, DECODE=1, EXECUTE=2, MEMORY=3, WRITEBACK=4 and HALT=5.
- R2: The instruction word is 21 bits wide and has four fields:
  - bits [20:15] hold the opcode;
  - bits [14:10] hold field A;
  - bits [9:5] hold field B;
  - bits [4:0] hold field C.
- R3: Opcode 000111 (add) writes reg[A] = (reg[B] + reg[C]) mod 256. The new value is visible only after the fifth clock edge of the instruction. During the WRITEBACK phase the old value is still read.
- R4: Opcode 000001 (move-immediate) writes the low 8 bits of instruction bits [9:0] to reg[A], at the same write-back edge as add.
- R5: Opcode 111001 (store) writes reg[A] to the data word at address ((reg[B] + C) mod 256) mod 32. The write happens at the fourth clock edge of the instruction, and the register file is left unchanged.
- R6: Any other opcode, including 000000 and 111111 with any non-all-ones fields, changes neither the registers nor the data store, and still takes five cycles.
- R7: Synchronous active-high reset sets the phase to FETCH, the program counter to 0 and every register to 0. The program counter advances by one at the end of FETCH and holds in every other phase.
- R8: Register 0 always reads as 0, and writes to it are discarded.
- R9: A fetched word of all ones moves the core to HALT on that edge. In HALT, halted reads 1, the program counter keeps the halt word's address, and the core stays in HALT until reset.
- R10: With ld_we high, ld_data is written at ld_addr into the instruction store when ld_dmem is 0. When ld_dmem is 1, the low 8 bits of ld_data go into the data store. dbg_reg_data and dbg_mem_data combinationally show the addressed register and data word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Store load write enable |
| ld_dmem | input | 1 | Load target: 0 instruction store, 1 data store |
| ld_addr | input | 5 | Load word address |
| ld_data | input | 21 | Load word; data store takes bits [7:0] |
| dbg_reg_addr | input | 5 | Debug register index |
| dbg_reg_data | output | 8 | Debug register value |
| dbg_mem_addr | input | 5 | Debug data store address |
| dbg_mem_data | output | 8 | Debug data store word |
| phase | output | 3 | Current phase code |
| pc | output | 5 | Program counter |
| halted | output | 1 | Core is in HALT |

## Verification
A state machine that skips or repeats a state shows within one cycle as an out-of-order phase code. It also shows as a program counter that moves outside FETCH. A latched instruction or operand register holding a stale value shows at the debug ports at the fourth or fifth edge of the instruction that uses it. It appears as a wrong register or data word, or as a write that lands one cycle early. Decode errors, such as a wrong opcode, field slice or address truncation, corrupt a register or data word that is compared against a model after every instruction.

// File: rtl/mc5_pkg.sv
package mc5_pkg;
    localparam int OPC_W = 6;

    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_EXEC   = 3'd2,
        PH_MEMORY = 3'd3,
        PH_WBACK  = 3'd4,
        PH_HALT   = 3'd5
    } phase_e;

    localparam logic [OPC_W-1:0] OPC_MOVI  = 6'b000001;
    localparam logic [OPC_W-1:0] OPC_ADD   = 6'b000111;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b111001;
endpackage

// File: rtl/mc5_mem.sv
module mc5_mem #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_b
);
    logic [WIDTH-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words_q[waddr] <= wdata;
        end
    end

    assign rdata_a = words_q[raddr_a];
    assign rdata_b = words_q[raddr_b];
endmodule

// File: rtl/mc5_regfile.sv
module mc5_regfile #(
    parameter int WIDTH = 8,
    parameter int NUM   = 32,
    localparam int AW = $clog2(NUM)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    ra,
    output logic [WIDTH-1:0] da,
    input  logic [AW-1:0]    rb,
    output logic [WIDTH-1:0] db,
    input  logic [AW-1:0]    rc,
    output logic [WIDTH-1:0] dc
);
    logic [WIDTH-1:0] regs_q [NUM];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM; i++) begin
                regs_q[i] <= '0;
            end
        end else if (we && (waddr != '0)) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign da = regs_q[ra];
    assign db = regs_q[rb];
    assign dc = regs_q[rc];

    AST_ZERO_REG_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rc == '0) |-> (dc == '0)); // R8
endmodule

// File: rtl/mc5_ctrl.sv
module mc5_ctrl
    import mc5_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int FLD_W  = 5,
    parameter int PC_W   = 5,
    parameter int DA_W   = 5,
    localparam int INSTR_W = OPC_W + 3 * FLD_W,
    localparam int IMM_W   = 2 * FLD_W
) (
    input  logic               clk,
    input  logic               rst,
    output logic [PC_W-1:0]    pc_o,
    input  logic [INSTR_W-1:0] instr_i,
    output logic [FLD_W-1:0]   rf_ra_o,
    input  logic [DATA_W-1:0]  rf_da_i,
    output logic [FLD_W-1:0]   rf_rb_o,
    input  logic [DATA_W-1:0]  rf_db_i,
    output logic               rf_we_o,
    output logic [FLD_W-1:0]   rf_wa_o,
    output logic [DATA_W-1:0]  rf_wd_o,
    output logic               dm_we_o,
    output logic [DA_W-1:0]    dm_wa_o,
    output logic [DATA_W-1:0]  dm_wd_o,
    output logic [2:0]         phase_o,
    output logic               halted_o
);
    phase_e state_q, state_d;
    logic [PC_W-1:0]    pc_q;
    logic [INSTR_W-1:0] ir_q;
    logic [DATA_W-1:0]  opa_q, opb_q, res_q;

    logic [OPC_W-1:0] opc;
    logic [FLD_W-1:0] fld_a, fld_b, fld_c;
    logic             fetch_stop;

    assign opc   = ir_q[INSTR_W-1 -: OPC_W];
    assign fld_a = ir_q[3*FLD_W-1 -: FLD_W];
    assign fld_b = ir_q[2*FLD_W-1 -: FLD_W];
    assign fld_c = ir_q[FLD_W-1:0];
    assign fetch_stop = (instr_i == '1);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_FETCH:  state_d = fetch_stop ? PH_HALT : PH_DECODE;
            PH_DECODE: state_d = PH_EXEC;
            PH_EXEC:   state_d = PH_MEMORY;
            PH_MEMORY: state_d = PH_WBACK;
            PH_WBACK:  state_d = PH_FETCH;
            PH_HALT:   state_d = PH_HALT;
            default:   state_d = PH_FETCH;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_FETCH;
        else     state_q <= state_d;
    end

    // datapath registers, loaded in their own phase
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
            opa_q <= '0;
            opb_q <= '0;
            res_q <= '0;
        end else begin
            unique case (state_q)
                PH_FETCH: begin
                    ir_q <= instr_i;
                    if (!fetch_stop) pc_q <= pc_q + 1'b1;
                end
                PH_DECODE: begin
                    opa_q <= rf_da_i;
                    opb_q <= rf_db_i;
                end
                PH_EXEC: begin
                    if (opc == OPC_ADD)        res_q <= opa_q + opb_q;
                    else if (opc == OPC_MOVI)  res_q <= DATA_W'(ir_q[IMM_W-1:0]);
                    else if (opc == OPC_STORE) res_q <= opa_q + DATA_W'(fld_c);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rf_ra_o  = fld_b;
        rf_rb_o  = (opc == OPC_STORE) ? fld_a : fld_c;
        rf_we_o  = (state_q == PH_WBACK) && ((opc == OPC_ADD) || (opc == OPC_MOVI));
        rf_wa_o  = fld_a;
        rf_wd_o  = res_q;
        dm_we_o  = (state_q == PH_MEMORY) && (opc == OPC_STORE);
        dm_wa_o  = res_q[DA_W-1:0];
        dm_wd_o  = opb_q;
        pc_o     = pc_q;
        phase_o  = state_q;
        halted_o = (state_q == PH_HALT);
    end

    AST_DECODE_TO_EXEC: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_DECODE) |=> (state_q == PH_EXEC)); // R1
    AST_EXEC_TO_MEMORY: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_EXEC) |=> (state_q == PH_MEMORY)); // R1
    AST_MEMORY_TO_WBACK: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_MEMORY) |=> (state_q == PH_WBACK)); // R1
    AST_WBACK_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_WBACK) |=> (state_q == PH_FETCH)); // R1
    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_FETCH && !fetch_stop) |=> (pc_q == $past(pc_q) + 1'b1)); // R7
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q != PH_FETCH) |=> $stable(pc_q)); // R7
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_HALT) |=> (state_q == PH_HALT && $stable(pc_q))); // R9
    AST_NO_RF_WRITE_ON_STORE: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |=> !rf_we_o); // R5
endmodule

// File: rtl/mc5_core.sv
module mc5_core
    import mc5_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NUM_REGS   = 32,
    parameter int IMEM_DEPTH = 32,
    parameter int DMEM_DEPTH = 32,
    localparam int FLD_W   = $clog2(NUM_REGS),
    localparam int INSTR_W = OPC_W + 3 * FLD_W,
    localparam int IA_W    = $clog2(IMEM_DEPTH),
    localparam int DA_W    = $clog2(DMEM_DEPTH),
    localparam int LD_AW   = (IA_W > DA_W) ? IA_W : DA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_we,
    input  logic               ld_dmem,
    input  logic [LD_AW-1:0]   ld_addr,
    input  logic [INSTR_W-1:0] ld_data,
    input  logic [FLD_W-1:0]   dbg_reg_addr,
    output logic [DATA_W-1:0]  dbg_reg_data,
    input  logic [DA_W-1:0]    dbg_mem_addr,
    output logic [DATA_W-1:0]  dbg_mem_data,
    output logic [2:0]         phase,
    output logic [IA_W-1:0]    pc,
    output logic               halted
);
    logic [INSTR_W-1:0] instr;
    logic [INSTR_W-1:0] imem_unused;
    logic [FLD_W-1:0]   rf_ra, rf_rb, rf_wa;
    logic [DATA_W-1:0]  rf_da, rf_db, rf_wd;
    logic               rf_we;
    logic               dm_we;
    logic [DA_W-1:0]    dm_wa;
    logic [DATA_W-1:0]  dm_wd;
    logic               dmem_we;
    logic [DA_W-1:0]    dmem_wa;
    logic [DATA_W-1:0]  dmem_wd;
    logic [DATA_W-1:0]  dmem_unused;
    logic               load_d;

    assign load_d  = ld_we && ld_dmem;
    assign dmem_we = dm_we || load_d;
    assign dmem_wa = load_d ? DA_W'(ld_addr) : dm_wa;
    assign dmem_wd = load_d ? ld_data[DATA_W-1:0] : dm_wd;

    mc5_mem #(.WIDTH(INSTR_W), .DEPTH(IMEM_DEPTH)) u_imem (
        .clk(clk), .we(ld_we && !ld_dmem), .waddr(IA_W'(ld_addr)), .wdata(ld_data),
        .raddr_a(pc), .rdata_a(instr), .raddr_b(pc), .rdata_b(imem_unused)
    );

    mc5_mem #(.WIDTH(DATA_W), .DEPTH(DMEM_DEPTH)) u_dmem (
        .clk(clk), .we(dmem_we), .waddr(dmem_wa), .wdata(dmem_wd),
        .raddr_a(dbg_mem_addr), .rdata_a(dbg_mem_data),
        .raddr_b(dm_wa), .rdata_b(dmem_unused)
    );

    mc5_regfile #(.WIDTH(DATA_W), .NUM(NUM_REGS)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_wa), .wdata(rf_wd),
        .ra(rf_ra), .da(rf_da), .rb(rf_rb), .db(rf_db),
        .rc(dbg_reg_addr), .dc(dbg_reg_data)
    );

    mc5_ctrl #(.DATA_W(DATA_W), .FLD_W(FLD_W), .PC_W(IA_W), .DA_W(DA_W)) u_ctrl (
        .clk(clk), .rst(rst), .pc_o(pc), .instr_i(instr),
        .rf_ra_o(rf_ra), .rf_da_i(rf_da), .rf_rb_o(rf_rb), .rf_db_i(rf_db),
        .rf_we_o(rf_we), .rf_wa_o(rf_wa), .rf_wd_o(rf_wd),
        .dm_we_o(dm_we), .dm_wa_o(dm_wa), .dm_wd_o(dm_wd),
        .phase_o(phase), .halted_o(halted)
    );

    AST_HALTED_MATCHES_PHASE: assert property (@(posedge clk) disable iff (rst)
        halted |-> (phase == 3'd5)); // R9
endmodule

// File: tb/tb_mc5_core.sv
`timescale 1ns/10ps
module tb_mc5_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_we = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [4:0]  ld_addr = '0;
    logic [20:0] ld_data = '0;
    logic [4:0]  dbg_reg_addr = '0;
    logic [7:0]  dbg_reg_data;
    logic [4:0]  dbg_mem_addr = '0;
    logic [7:0]  dbg_mem_data;
    logic [2:0]  phase;
    logic [4:0]  pc;
    logic        halted;

    int n_chk = 0;
    int n_fail = 0;

    logic [20:0] prog [32];
    int          prog_len;
    logic [7:0]  ref_rf [32];
    logic [7:0]  ref_dm [32];

    localparam logic [5:0] T_ADD = 6'b000111, T_MOVI = 6'b000001, T_STORE = 6'b111001;

    always #5 clk = ~clk;

    mc5_core dut (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
        .ld_data(ld_data), .dbg_reg_addr(dbg_reg_addr), .dbg_reg_data(dbg_reg_data),
        .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data),
        .phase(phase), .pc(pc), .halted(halted)
    );

    function automatic logic [20:0] enc(logic [5:0] op, logic [4:0] a, logic [4:0] b, logic [4:0] c);
        return {op, a, b, c};
    endfunction

    function automatic logic [20:0] movi(logic [4:0] rd, logic [9:0] imm);
        return {T_MOVI, rd, imm};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic compare_state(input string req);
        for (int i = 0; i < 32; i++) begin
            dbg_reg_addr = 5'(i);
            #0.05;
            chk(req, $sformatf("reg %0d", i), dbg_reg_data, ref_rf[i]);
        end
        for (int i = 0; i < 32; i++) begin
            dbg_mem_addr = 5'(i);
            #0.05;
            chk(req, $sformatf("dmem %0d", i), dbg_mem_data, ref_dm[i]);
        end
    endtask

    // reset, load program (rest halt words) and data preset, release reset
    task automatic boot();
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            ld_we = 1'b1; ld_dmem = 1'b0; ld_addr = 5'(i);
            ld_data = (i < prog_len) ? prog[i] : '1;
            @(negedge clk);
        end
        for (int i = 0; i < 32; i++) begin
            ld_we = 1'b1; ld_dmem = 1'b1; ld_addr = 5'(i);
            ld_data = 21'(8'(i * 3 + 1));
            ref_dm[i] = 8'(i * 3 + 1);
            ref_rf[i] = '0;
            @(negedge clk);
        end
        ld_we = 1'b0; ld_dmem = 1'b0;
        rst = 1'b0;
    endtask

    // run one instruction starting at a FETCH-phase negedge
    task automatic run_one(input string req, input int at);
        logic [20:0] w;
        logic [5:0]  op;
        logic [4:0]  a, b, c, sa;
        logic [7:0]  s8;
        w = prog[at];
        op = w[20:15]; a = w[14:10]; b = w[9:5]; c = w[4:0];
        s8 = ref_rf[b] + {3'b000, c};
        sa = s8[4:0];
        chk("R1", "phase fetch", phase, 0);
        chk("R7", "pc at fetch", pc, 5'(at));
        step(); chk("R1", "phase decode", phase, 1);
        chk("R7", "pc after fetch", pc, 5'(at + 1));
        step(); chk("R1", "phase execute", phase, 2);
        step(); chk("R1", "phase memory", phase, 3);
        chk("R7", "pc held", pc, 5'(at + 1));
        if (op == T_STORE) begin
            dbg_mem_addr = sa; #0.05;
            chk("R5", "store not before memory edge", dbg_mem_data, ref_dm[sa]);
        end
        step(); chk("R1", "phase writeback", phase, 4);
        if (op == T_STORE) begin
            dbg_mem_addr = sa; #0.05;
            chk("R5", "store after memory edge", dbg_mem_data, ref_rf[a]);
        end
        if ((op == T_ADD || op == T_MOVI) && a != 0) begin
            dbg_reg_addr = a; #0.05;
            chk(op == T_ADD ? "R3" : "R4", "old value during writeback", dbg_reg_data, ref_rf[a]);
        end
        step(); chk("R1", "phase back to fetch", phase, 0);
        if (op == T_ADD && a != 0)        ref_rf[a] = ref_rf[b] + ref_rf[c];
        else if (op == T_MOVI && a != 0)  ref_rf[a] = w[7:0];
        else if (op == T_STORE)           ref_dm[sa] = ref_rf[a];
        compare_state(req);
    endtask

    task automatic run_prog(input string req);
        for (int i = 0; i < prog_len; i++) run_one(req, i);
    endtask

    task automatic t_reset_state();
        prog_len = 0;
        boot();
        chk("R7", "reset phase", phase, 0);
        chk("R7", "reset pc", pc, 0);
        chk("R9", "reset halted", halted, 0);
        compare_state("R10");
    endtask

    task automatic t_add_basic();
        prog[0] = movi(5'd2, 10'h02A);
        prog[1] = movi(5'd3, 10'h012);
        prog[2] = enc(T_ADD, 5'd1, 5'd2, 5'd3);
        prog[3] = enc(T_STORE, 5'd1, 5'd4, 5'd0);
        prog_len = 4;
        boot();
        run_prog("R3");
        dbg_reg_addr = 5'd1; #0.05;
        chk("R3", "add 2A+12", dbg_reg_data, 8'h3C);
        dbg_mem_addr = 5'd0; #0.05;
        chk("R5", "store r1 to 0", dbg_mem_data, 8'h3C);
    endtask

    task automatic t_add_wrap();
        prog[0] = movi(5'd2, 10'h3FF);
        prog[1] = movi(5'd3, 10'h001);
        prog[2] = enc(T_ADD, 5'd4, 5'd2, 5'd3);
        prog[3] = enc(T_ADD, 5'd5, 5'd2, 5'd2);
        prog[4] = enc(T_ADD, 5'd2, 5'd2, 5'd3);
        prog_len = 5;
        boot();
        run_prog("R4");
        dbg_reg_addr = 5'd4; #0.05;
        chk("R3", "wrap FF+01", dbg_reg_data, 8'h00);
        dbg_reg_addr = 5'd5; #0.05;
        chk("R3", "FF+FF", dbg_reg_data, 8'hFE);
        dbg_reg_addr = 5'd3; #0.05;
        chk("R4", "movi low bits", dbg_reg_data, 8'h01);
    endtask

    task automatic t_zero_reg();
        prog[0] = movi(5'd0, 10'h012);
        prog[1] = movi(5'd2, 10'h005);
        prog[2] = enc(T_ADD, 5'd0, 5'd2, 5'd2);
        prog[3] = enc(T_ADD, 5'd6, 5'd0, 5'd2);
        prog_len = 4;
        boot();
        run_prog("R8");
        dbg_reg_addr = 5'd0; #0.05;
        chk("R8", "reg0 stays zero", dbg_reg_data, 8'h00);
        dbg_reg_addr = 5'd6; #0.05;
        chk("R8", "reg0 as source", dbg_reg_data, 8'h05);
    endtask

    task automatic t_store_offset();
        prog[0] = movi(5'd5, 10'h001);
        prog[1] = movi(5'd6, 10'h077);
        prog[2] = enc(T_STORE, 5'd6, 5'd5, 5'd3);
        prog[3] = movi(5'd7, 10'h01F);
        prog[4] = enc(T_STORE, 5'd6, 5'd7, 5'd31);
        prog[5] = movi(5'd8, 10'h0F0);
        prog[6] = enc(T_STORE, 5'd6, 5'd8, 5'd31);
        prog_len = 7;
        boot();
        run_prog("R5");
        dbg_mem_addr = 5'd4; #0.05;
        chk("R5", "base 1 offset 3", dbg_mem_data, 8'h77);
        dbg_mem_addr = 5'd30; #0.05;
        chk("R5", "address wrap to 30", dbg_mem_data, 8'h77);
        dbg_mem_addr = 5'd15; #0.05;
        chk("R5", "8-bit sum F0+1F truncated", dbg_mem_data, 8'h77);
        dbg_reg_addr = 5'd6; #0.05;
        chk("R5", "source register untouched", dbg_reg_data, 8'h77);
    endtask

    task automatic t_unknown_ops();
        prog[0] = movi(5'd9, 10'h0AB);
        prog[1] = enc(6'b000000, 5'd9, 5'd9, 5'd9);
        prog[2] = enc(6'b111111, 5'd31, 5'd31, 5'd30);
        prog[3] = enc(6'b111000, 5'd9, 5'd0, 5'd1);
        prog[4] = enc(6'b000110, 5'd9, 5'd9, 5'd9);
        prog_len = 5;
        boot();
        run_prog("R6");
        dbg_reg_addr = 5'd9; #0.05;
        chk("R6", "reg after no-ops", dbg_reg_data, 8'hAB);
        chk("R2", "pc after five words", pc, 5);
    endtask

    task automatic t_halt();
        prog[0] = movi(5'd7, 10'h055);
        prog_len = 1;
        boot();
        run_prog("R9");
        chk("R9", "not halted before fetch", halted, 0);
        step();
        chk("R9", "halted set", halted, 1);
        chk("R9", "halt phase code", phase, 5);
        chk("R9", "pc kept at halt word", pc, 1);
        repeat (6) step();
        chk("R9", "halt sticky", halted, 1);
        chk("R9", "pc still held", pc, 1);
        compare_state("R9");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_add_basic();
        t_add_wrap();
        t_zero_reg();
        t_store_offset();
        t_unknown_ops();
        t_halt();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule